// File: doc/BRIEF.md
# Fixed Off-Time PWM Current Chopper

This block sequences the chopping of one H-bridge winding so that its current is held near a target level. While the bridge drives, current builds up through the winding and the sense resistor. A synchronised comparator input reports when that current reaches the target. The block then stops driving for an off-time of a fixed number of clock cycles, and current decays in the manner the translator selects. When the off-time ends, the bridge drives again. For a programmed number of cycles after drive begins, the comparator is not looked at. This rejects the transients that switching produces.

The output is a two-bit bridge command for the gate-drive logic. The allowed values are off, drive, fast decay and slow decay. In mixed decay, each off-time opens with a fast-decay portion of programmed length and finishes in slow decay. The bridge command is forced to off while the active-low output enable is high or while a fault is present. When the commanded current is zero, the bridge is held in slow decay. Off-time, blanking and fast-portion lengths are static configuration inputs counted in clock cycles.

Top module: `chop_seq`

## Requirements
- R1: `bridge_state` is 2'b00 (off) while `rst_n` is low. At the first clock edge with reset released, the block moves to 2'b01 (drive), provided it is enabled and the commanded current is nonzero. The other codes are 2'b10 (fast decay) and 2'b11 (slow decay).
- R2: While `out_en_n` is high, `bridge_state` reads 2'b00 in the same cycle. After `out_en_n` returns low, drive starts in the next cycle, with fresh blanking.
- R3: While `fault` is high, `bridge_state` reads 2'b00 in the same cycle. After `fault` clears, drive starts in the next cycle.
- R4: With `blank_cycles` = N, a trip is ignored in the first N cycles of each drive interval. A trip seen in drive cycle N+1 or later moves the bridge into the off-time at the next cycle.
- R5: A trip that arrives only during blanking is discarded and not stored. Drive continues after blanking ends until a new trip arrives.
- R6: The off-time lasts exactly `off_cycles` cycles, with a value of 0 treated as 1. Drive then resumes with blanking restarted.
- R7: `decay_mode` 2'b00 gives slow decay (2'b11) for the whole off-time. `decay_mode` 2'b01 gives fast decay (2'b10) for the whole off-time.
- R8: `decay_mode` 2'b10 or 2'b11 (mixed) gives fast decay in off-time cycles 1..`fast_cycles` and slow decay after that. A `fast_cycles` of 0 yields all slow. A `fast_cycles` of at least `off_cycles` yields all fast.
- R9: While `cur_zero` is high and the block is enabled, the block never drives. A drive interval is left at the next cycle, and any off-time cycle reads slow decay. Once `cur_zero` falls after the off-time has expired, drive resumes at the next cycle.
- R10: The decay mode is captured at the trip. A change of `decay_mode` during an off-time does not affect that off-time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_en_n | input | 1 | Active-low bridge output enable |
| fault | input | 1 | Fault present (thermal, gate supply, logic supply) |
| cur_zero | input | 1 | Commanded winding current is zero |
| trip | input | 1 | Synchronised current-trip comparator |
| decay_mode | input | 2 | 00 slow, 01 fast, 1x mixed |
| off_cycles | input | CW | Fixed off-time length in cycles |
| blank_cycles | input | CW | Comparator blanking length in cycles |
| fast_cycles | input | CW | Fast portion of mixed decay in cycles |
| bridge_state | output | 2 | 00 off, 01 drive, 10 fast decay, 11 slow decay |

## Verification
An elapsed-cycle counter that is wrong shows up directly as an off-time of the wrong length. It also moves the point where mixed decay switches from fast to slow, and both effects appear within the first off-time after a trip. A blanking counter that fails to reload on re-entry to drive lets an early trip end drive one or more cycles too soon. A wrong captured mode shows as the wrong decay code on the first off cycle. Disable and fault handling are combinational at the output, so an error there appears in the same cycle.

// File: rtl/chop_seq.sv
module chop_seq #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          out_en_n,
  input  logic          fault,
  input  logic          cur_zero,
  input  logic          trip,
  input  logic [1:0]    decay_mode,
  input  logic [CW-1:0] off_cycles,
  input  logic [CW-1:0] blank_cycles,
  input  logic [CW-1:0] fast_cycles,
  output logic [1:0]    bridge_state
);
  localparam logic [1:0] ST_OFF  = 2'b00;
  localparam logic [1:0] ST_DRV  = 2'b01;
  localparam logic [1:0] ST_FAST = 2'b10;
  localparam logic [1:0] ST_SLOW = 2'b11;

  typedef enum logic [1:0] {PH_IDLE, PH_DRIVE, PH_DECAY} phase_t;

  phase_t        phase;
  logic [CW-1:0] elapsed;
  logic [CW-1:0] blank_rem;
  logic [1:0]    mode_q;

  logic          active, blank_busy, off_done, fast_now;
  logic [CW-1:0] off_len;

  assign active     = !out_en_n && !fault;
  assign off_len    = (off_cycles == '0) ? CW'(1) : off_cycles;
  assign off_done   = elapsed >= off_len;
  assign blank_busy = blank_rem != '0;
  assign fast_now   = (mode_q == 2'b01) || (mode_q[1] && elapsed <= fast_cycles);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      elapsed   <= '0;
      blank_rem <= '0;
      mode_q    <= 2'b00;
    end else if (!active) begin
      phase <= PH_IDLE;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (cur_zero) begin
            phase   <= PH_DECAY;
            elapsed <= off_len;
            mode_q  <= 2'b00;
          end else begin
            phase     <= PH_DRIVE;
            blank_rem <= blank_cycles;
          end
        end
        PH_DRIVE: begin
          if (cur_zero) begin
            phase   <= PH_DECAY;
            elapsed <= off_len;
            mode_q  <= 2'b00;
          end else if (trip && !blank_busy) begin
            phase   <= PH_DECAY;
            elapsed <= CW'(1);
            mode_q  <= decay_mode;
          end else if (blank_busy) begin
            blank_rem <= blank_rem - CW'(1);
          end
        end
        PH_DECAY: begin
          if (!off_done) begin
            elapsed <= elapsed + CW'(1);
          end else if (!cur_zero) begin
            phase     <= PH_DRIVE;
            blank_rem <= blank_cycles;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    if (!active || phase == PH_IDLE) bridge_state = ST_OFF;
    else if (phase == PH_DRIVE)      bridge_state = ST_DRV;
    else if (cur_zero)               bridge_state = ST_SLOW;
    else if (fast_now)               bridge_state = ST_FAST;
    else                             bridge_state = ST_SLOW;
  end
endmodule

// File: rtl/chop_seq_chk.sv
module chop_seq_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          out_en_n,
  input logic          fault,
  input logic          cur_zero,
  input logic          trip,
  input logic [CW-1:0] off_cycles,
  input logic [CW-1:0] blank_cycles,
  input logic [1:0]    bridge_state
);
  logic [CW:0] drv_run, dec_run;
  logic [CW:0] off_len;
  logic        in_decay;

  assign off_len  = (off_cycles == '0) ? (CW+1)'(1) : {1'b0, off_cycles};
  assign in_decay = bridge_state[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drv_run <= '0;
      dec_run <= '0;
    end else begin
      drv_run <= (bridge_state == 2'b01) ? ((&drv_run) ? drv_run : drv_run + 1'b1) : '0;
      dec_run <= in_decay ? ((&dec_run) ? dec_run : dec_run + 1'b1) : '0;
    end
  end

  AST_DISABLED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_en_n || fault) |-> bridge_state == 2'b00); // R2

  AST_FAULT_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(fault) && fault) |-> bridge_state == 2'b00); // R3

  AST_BLANK_HOLDS_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (bridge_state == 2'b01 && drv_run < {1'b0, blank_cycles} && !cur_zero)
      |=> (bridge_state == 2'b01 || out_en_n || fault)); // R4

  AST_DRIVE_EXIT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bridge_state) == 2'b01 && bridge_state[1]) |-> ($past(trip) || $past(cur_zero))); // R4

  AST_OFF_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    (in_decay && dec_run + 1'b1 < off_len && !cur_zero && !$past(cur_zero))
      |=> (bridge_state[1] || out_en_n || fault)); // R6

  AST_NO_SLOW_TO_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bridge_state) == 2'b11 && !$past(cur_zero) && in_decay) |-> bridge_state == 2'b11); // R8

  AST_ZERO_SLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_zero && $past(cur_zero) && !out_en_n && !fault && !$past(out_en_n) && !$past(fault))
      |-> bridge_state == 2'b11); // R9
endmodule

bind chop_seq chop_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .out_en_n(out_en_n), .fault(fault),
  .cur_zero(cur_zero), .trip(trip), .off_cycles(off_cycles),
  .blank_cycles(blank_cycles), .bridge_state(bridge_state)
);

// File: tb/chop_seq_test.sv
module chop_seq_test;
  localparam int CW = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam logic [1:0] OFF = 2'b00, DRV = 2'b01, FST = 2'b10, SLW = 2'b11;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          out_en_n = 1'b0;
  logic          fault = 1'b0;
  logic          cur_zero = 1'b0;
  logic          trip = 1'b0;
  logic [1:0]    decay_mode = 2'b00;
  logic [CW-1:0] off_cycles = 16'd4;
  logic [CW-1:0] blank_cycles = 16'd2;
  logic [CW-1:0] fast_cycles = 16'd1;
  logic [1:0]    bridge_state;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chop_seq #(.CW(CW)) uut (
    .clk(clk), .rst_n(rst_n), .out_en_n(out_en_n), .fault(fault),
    .cur_zero(cur_zero), .trip(trip), .decay_mode(decay_mode),
    .off_cycles(off_cycles), .blank_cycles(blank_cycles),
    .fast_cycles(fast_cycles), .bridge_state(bridge_state)
  );

  function automatic logic [1:0] exp_off(input logic [1:0] m, input int f, input int e);
    if (m == 2'b00) return SLW;
    if (m == 2'b01) return FST;
    return (e <= f) ? FST : SLW;
  endfunction

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic disable_bridge();
    out_en_n = 1'b1;
    #1 chk("R2 disable same cycle", bridge_state, OFF);
    tick();
  endtask

  task automatic run_chop(input logic [1:0] m, input int t, input int n, input int f);
    int tl;
    tl = (t == 0) ? 1 : t;
    disable_bridge();
    decay_mode = m; off_cycles = CW'(t); blank_cycles = CW'(n); fast_cycles = CW'(f);
    trip = 1'b1;
    out_en_n = 1'b0;
    #1 chk("R2 off before enable edge", bridge_state, OFF);
    tick();
    for (int k = 1; k <= n + 1; k++) begin
      chk("R4 drive through blanking", bridge_state, DRV);
      tick();
    end
    for (int e = 1; e <= tl; e++) begin
      if (m[1]) chk("R8 mixed split", bridge_state, exp_off(m, f, e));
      else      chk("R7 fixed decay", bridge_state, exp_off(m, f, e));
      if (e == 1) decay_mode = ~m;
      if (e == tl) trip = 1'b0;
      tick();
    end
    chk("R6 drive after off-time", bridge_state, DRV);
    decay_mode = m;
    tick();
    chk("R10 drive holds without trip", bridge_state, DRV);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7741));
    @(negedge clk);
    chk("R1 reset off", bridge_state, OFF);
    tick();
    chk("R1 reset held off", bridge_state, OFF);
    rst_n = 1'b1;
    tick();
    chk("R1 drive after reset release", bridge_state, DRV);

    run_chop(2'b00, 5, 2, 0);
    run_chop(2'b01, 5, 2, 0);
    run_chop(2'b10, 6, 1, 2);
    run_chop(2'b10, 6, 0, 0);
    run_chop(2'b11, 4, 3, 9);
    run_chop(2'b10, 0, 0, 3);
    run_chop(2'b01, 1, 0, 0);

    // R5: trip only during blanking is dropped
    disable_bridge();
    blank_cycles = 16'd4; off_cycles = 16'd3; decay_mode = 2'b01;
    out_en_n = 1'b0;
    tick();
    trip = 1'b1;
    tick();
    trip = 1'b0;
    for (int k = 0; k < 8; k++) begin
      chk("R5 no queued trip", bridge_state, DRV);
      tick();
    end
    trip = 1'b1;
    tick();
    chk("R5 fresh trip accepted", bridge_state, FST);
    trip = 1'b0;

    // R3: fault during off-time
    fault = 1'b1;
    #1 chk("R3 fault off same cycle", bridge_state, OFF);
    tick();
    chk("R3 fault held off", bridge_state, OFF);
    fault = 1'b0;
    #1 chk("R3 off in clearing cycle", bridge_state, OFF);
    tick();
    chk("R3 drive after fault clear", bridge_state, DRV);

    // R9: zero current
    blank_cycles = 16'd0; off_cycles = 16'd3;
    cur_zero = 1'b1;
    tick();
    chk("R9 leave drive on zero", bridge_state, SLW);
    for (int k = 0; k < 10; k++) begin
      tick();
      chk("R9 parked slow", bridge_state, SLW);
    end
    cur_zero = 1'b0;
    tick();
    chk("R9 drive after zero release", bridge_state, DRV);
    decay_mode = 2'b01; off_cycles = 16'd6;
    trip = 1'b1;
    tick();
    trip = 1'b0;
    chk("R9 fast before zero", bridge_state, FST);
    cur_zero = 1'b1;
    #1 chk("R9 zero forces slow", bridge_state, SLW);
    tick();
    chk("R9 zero keeps slow", bridge_state, SLW);
    cur_zero = 1'b0;
    tick();

    for (int i = 0; i < 40; i++) begin
      run_chop(2'($urandom_range(0, 3)), $urandom_range(1, 20),
               $urandom_range(0, 6), $urandom_range(0, 25));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule